// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a 16-bit write/read bus and an on-chip flash array. A bus write is treated as a command, or as one step of a command that spans several bus cycles. The block runs the matching array operation and sets what later bus reads return. Depending on the last command, a read returns array data, the status byte, or the lock state of one block. The block holds the read mode, two sticky error flags and one lock flag per block.

Erase and program work go to a behavioural array model through a request/busy/done handshake, one unit of work at a time. The model erases a whole block, or programs one word by clearing bits only. Its latencies are parameters. Page programming collects a full page of words in a local buffer first. It then writes them to the array one after another. The model's contents are all ones after reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data, the status byte reads 0x80 (ready, no errors), every block reads as unlocked, and every array word reads 0xFFFF.
- R2: Only bits 7:0 of a command write are decoded, and bits 15:8 are ignored. After code 0xFF, every read returns the 16-bit array word at the read address, and this holds until another command arrives.
- R3: After code 0x70, reads return the status byte on bits 7:0 with bits 15:8 zero. In the status byte, bit 7 = ready, bit 5 = erase error, bit 4 = program error, and all other bits are 0.
- R4: Code 0x50, written while ready, clears status bits 5 down to 3 and leaves the read mode unchanged.
- R5: Code 0x20 followed by 0xD0 (block taken from address bits above the block size) sets every word of that block to 0xFFFF. From the confirm write until the end, status bit 7 is 0 and reads return status.
- R6: A second write other than 0xD0 after 0x20 or 0xA7 sets bit 5. After 0x77 it sets bit 4. Either way the block goes back to idle in status read mode, and the array is left alone.
- R7: Code 0x77 followed by 0xD0 locks the addressed block. After code 0x71, a read of an address in a block returns bit 6 = 1 if the block is unlocked and 0 if it is locked, with all other bits 0.
- R8: A block erase or a page program aimed at a locked block is refused. The refusal sets bit 5 (erase) or bit 4 (program), and the array is left unchanged.
- R9: Code 0xA7 followed by 0xD0 erases every unlocked block and skips the locked ones.
- R10: Code 0x41 is followed by 128 word writes. Within one 256-byte page, their address bits 7:1 must run 0 to 127 in order, with bit 0 = 0. The data is then programmed so that each word ends as old AND new.
- R11: A page-load write with an odd address, a wrong offset, or a different page sets bit 4, returns to idle in status read mode, and programs nothing.
- R12: While an erase or program runs, writes other than 0x70 are ignored, and 0x70 selects status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 11 | Byte address of the write or read (even) |
| bus_wdata | input | 16 | Write data; command code on bits 7:0 |
| bus_rdata | output | 16 | Read data, selected by the current read mode |

## Verification
The bench uses four blocks of 256 words, 128-word pages, an erase latency of 16 cycles and a program latency of 3 cycles. With these short latencies, full page programs, a block erase and an erase of all unlocked blocks each finish within a few hundred cycles. That leaves time to send commands while the array is still busy. With four blocks, one erase-all pass can cover a locked block between unlocked ones. A mid-run reset clears the lock flags, so one block can hold data and then be locked before the erase-all pass.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_ERASE_BLK  = 8'h20;
    localparam logic [7:0] CMD_ERASE_ALL  = 8'hA7;
    localparam logic [7:0] CMD_LOCK_PROG  = 8'h77;
    localparam logic [7:0] CMD_RD_LOCK    = 8'h71;
    localparam logic [7:0] CMD_PAGE_PROG  = 8'h41;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

    localparam int LOCK_RD_BIT = 6;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_LOCK
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CONFIRM,
        PH_LOAD,
        PH_ISSUE,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        JOB_ERASE,
        JOB_ERASE_ALL,
        JOB_PROG
    } job_e;

    typedef enum logic {
        OP_ERASE,
        OP_PROG
    } arr_op_e;

    typedef struct packed {
        logic ready;
        logic erase_err;
        logic prog_err;
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        return {s.ready, 1'b0, s.erase_err, s.prog_err, 4'b0000};
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic [BLK_W-1:0]      set_idx,
    output logic [NUM_BLOCKS-1:0] locks
);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                locks[b] <= 1'b0;
            end else if (set_en && (set_idx == BLK_W'(b))) begin
                locks[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
    parameter int PAGE_WORDS = 128,
    localparam int PG_W = $clog2(PAGE_WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [PG_W-1:0] widx,
    input  logic [15:0]     wdata,
    input  logic [PG_W-1:0] ridx,
    output logic [15:0]     rdata
);

    logic [15:0] buf_q [PAGE_WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            buf_q[widx] <= wdata;
        end
    end

    assign rdata = buf_q[ridx];

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 256,
    parameter int ERASE_LAT   = 16,
    parameter int PROG_LAT    = 3,
    localparam int BLK_W   = $clog2(NUM_BLOCKS),
    localparam int BW_W    = $clog2(BLOCK_WORDS),
    localparam int WA_W    = BLK_W + BW_W,
    localparam int WORDS   = NUM_BLOCKS * BLOCK_WORDS,
    localparam int LAT_MAX = max_int(ERASE_LAT, PROG_LAT),
    localparam int TM_W    = $clog2(LAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  arr_op_e          op,
    input  logic [BLK_W-1:0] blk,
    input  logic [WA_W-1:0]  waddr,
    input  logic [15:0]      wdata,
    input  logic [WA_W-1:0]  raddr,
    output logic [15:0]      rdata,
    output logic             busy,
    output logic             done
);

    logic [15:0]      mem [WORDS];
    logic [TM_W-1:0]  timer_q;
    arr_op_e          op_q;
    logic [BLK_W-1:0] blk_q;
    logic [WA_W-1:0]  addr_q;
    logic [15:0]      data_q;
    logic             finish;

    assign finish = busy && (timer_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            timer_q <= '0;
            op_q    <= OP_ERASE;
            blk_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && req) begin
                busy    <= 1'b1;
                timer_q <= (op == OP_ERASE) ? TM_W'(ERASE_LAT - 1) : TM_W'(PROG_LAT - 1);
                op_q    <= op;
                blk_q   <= blk;
                addr_q  <= waddr;
                data_q  <= wdata;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else if (finish) begin
            if (op_q == OP_ERASE) begin
                for (int i = 0; i < BLOCK_WORDS; i++) begin
                    mem[{blk_q, BW_W'(i)}] <= '1;
                end
            end else begin
                mem[addr_q] <= mem[addr_q] & data_q;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 256,
    parameter int PAGE_WORDS  = 128,
    localparam int BLK_W   = $clog2(NUM_BLOCKS),
    localparam int BW_W    = $clog2(BLOCK_WORDS),
    localparam int WA_W    = BLK_W + BW_W,
    localparam int AW      = WA_W + 1,
    localparam int PG_W    = $clog2(PAGE_WORDS),
    localparam int PB_W    = WA_W - PG_W,
    localparam int CNT_MAX = max_int(PAGE_WORDS, NUM_BLOCKS),
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [7:0]            cmd,
    input  logic [NUM_BLOCKS-1:0] lock_vec,
    input  logic                  arr_done,
    output phase_e                phase,
    output rd_mode_e              mode,
    output status_t               status,
    output logic                  lock_set,
    output logic [BLK_W-1:0]      lock_idx,
    output logic                  pb_we,
    output logic [PG_W-1:0]       pb_idx,
    output logic                  arr_req,
    output arr_op_e               arr_op,
    output logic [BLK_W-1:0]      arr_blk,
    output logic [WA_W-1:0]       arr_waddr
);

    phase_e           phase_q;
    rd_mode_e         mode_q;
    job_e             job_q;
    logic             err_erase_q;
    logic             err_prog_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BLK_W-1:0] blk_q;
    logic [7:0]       pend_q;
    logic [PB_W-1:0]  page_q;

    logic [BLK_W-1:0] w_blk;
    logic [PG_W-1:0]  w_off;
    logic [PB_W-1:0]  w_page;
    logic [CNT_W-1:0] job_limit;
    logic             busy;
    logic             job_done;
    logic             ea_skip;
    logic             load_bad;
    logic             last_word;

    assign w_blk  = bus_addr[AW-1 -: BLK_W];
    assign w_off  = bus_addr[PG_W:1];
    assign w_page = bus_addr[AW-1:PG_W+1];

    always_comb begin
        case (job_q)
            JOB_ERASE_ALL: job_limit = CNT_W'(NUM_BLOCKS);
            JOB_PROG:      job_limit = CNT_W'(PAGE_WORDS);
            default:       job_limit = CNT_W'(1);
        endcase
    end

    assign busy      = (phase_q == PH_ISSUE) || (phase_q == PH_WAIT);
    assign job_done  = (cnt_q == job_limit);
    assign ea_skip   = (job_q == JOB_ERASE_ALL) && lock_vec[cnt_q[BLK_W-1:0]];
    assign last_word = (cnt_q == CNT_W'(PAGE_WORDS - 1));
    assign load_bad  = bus_addr[0]
                     || (w_off != cnt_q[PG_W-1:0])
                     || ((cnt_q != '0) && (w_page != page_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            mode_q      <= RM_ARRAY;
            job_q       <= JOB_ERASE;
            err_erase_q <= 1'b0;
            err_prog_q  <= 1'b0;
            cnt_q       <= '0;
            blk_q       <= '0;
            pend_q      <= '0;
            page_q      <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (bus_we) begin
                        case (cmd)
                            CMD_RD_ARRAY:   mode_q <= RM_ARRAY;
                            CMD_RD_STATUS:  mode_q <= RM_STATUS;
                            CMD_RD_LOCK:    mode_q <= RM_LOCK;
                            CMD_CLR_STATUS: begin
                                err_erase_q <= 1'b0;
                                err_prog_q  <= 1'b0;
                            end
                            CMD_ERASE_BLK, CMD_ERASE_ALL, CMD_LOCK_PROG: begin
                                pend_q  <= cmd;
                                phase_q <= PH_CONFIRM;
                            end
                            CMD_PAGE_PROG: begin
                                cnt_q   <= '0;
                                phase_q <= PH_LOAD;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_CONFIRM: begin
                    if (bus_we) begin
                        phase_q <= PH_IDLE;
                        mode_q  <= RM_STATUS;
                        if (cmd != CMD_CONFIRM) begin
                            if (pend_q == CMD_LOCK_PROG) err_prog_q  <= 1'b1;
                            else                         err_erase_q <= 1'b1;
                        end else if (pend_q == CMD_ERASE_BLK) begin
                            if (lock_vec[w_blk]) begin
                                err_erase_q <= 1'b1;
                            end else begin
                                blk_q   <= w_blk;
                                job_q   <= JOB_ERASE;
                                cnt_q   <= '0;
                                phase_q <= PH_ISSUE;
                            end
                        end else if (pend_q == CMD_ERASE_ALL) begin
                            job_q   <= JOB_ERASE_ALL;
                            cnt_q   <= '0;
                            phase_q <= PH_ISSUE;
                        end
                    end
                end
                PH_LOAD: begin
                    if (bus_we) begin
                        if (load_bad) begin
                            err_prog_q <= 1'b1;
                            mode_q     <= RM_STATUS;
                            phase_q    <= PH_IDLE;
                        end else begin
                            if (cnt_q == '0) page_q <= w_page;
                            if (last_word) begin
                                mode_q <= RM_STATUS;
                                cnt_q  <= '0;
                                if (lock_vec[w_blk]) begin
                                    err_prog_q <= 1'b1;
                                    phase_q    <= PH_IDLE;
                                end else begin
                                    job_q   <= JOB_PROG;
                                    phase_q <= PH_ISSUE;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                end
                PH_ISSUE: begin
                    if (job_done)     phase_q <= PH_IDLE;
                    else if (ea_skip) cnt_q   <= cnt_q + 1'b1;
                    else              phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (arr_done) begin
                        cnt_q   <= cnt_q + 1'b1;
                        phase_q <= PH_ISSUE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
            if (busy && bus_we && (cmd == CMD_RD_STATUS)) begin
                mode_q <= RM_STATUS;
            end
        end
    end

    assign phase     = phase_q;
    assign mode      = mode_q;
    assign status    = '{ready: !busy, erase_err: err_erase_q, prog_err: err_prog_q};
    assign lock_set  = (phase_q == PH_CONFIRM) && bus_we && (cmd == CMD_CONFIRM)
                     && (pend_q == CMD_LOCK_PROG);
    assign lock_idx  = w_blk;
    assign pb_we     = (phase_q == PH_LOAD) && bus_we && !load_bad;
    assign pb_idx    = cnt_q[PG_W-1:0];
    assign arr_req   = (phase_q == PH_ISSUE) && !job_done && !ea_skip;
    assign arr_op    = (job_q == JOB_PROG) ? OP_PROG : OP_ERASE;
    assign arr_blk   = (job_q == JOB_ERASE_ALL) ? cnt_q[BLK_W-1:0] : blk_q;
    assign arr_waddr = {page_q, cnt_q[PG_W-1:0]};

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 256,
    parameter int PAGE_WORDS  = 128,
    parameter int ERASE_LAT   = 16,
    parameter int PROG_LAT    = 3,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int BW_W  = $clog2(BLOCK_WORDS),
    localparam int WA_W  = BLK_W + BW_W,
    localparam int AW    = WA_W + 1,
    localparam int PG_W  = $clog2(PAGE_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata
);

    phase_e                fsm_phase;
    rd_mode_e              rd_mode;
    status_t               st;
    logic                  lock_set;
    logic [BLK_W-1:0]      lock_idx;
    logic [NUM_BLOCKS-1:0] lock_vec;
    logic                  pb_we;
    logic [PG_W-1:0]       pb_idx;
    logic [15:0]           pb_rdata;
    logic                  arr_req;
    arr_op_e               arr_op;
    logic [BLK_W-1:0]      arr_blk;
    logic [WA_W-1:0]       arr_waddr;
    logic [15:0]           arr_rdata;
    logic                  arr_busy;
    logic                  arr_done;
    logic [BLK_W-1:0]      rd_blk;

    flash_cmd_fsm #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .cmd      (bus_wdata[7:0]),
        .lock_vec (lock_vec),
        .arr_done (arr_done),
        .phase    (fsm_phase),
        .mode     (rd_mode),
        .status   (st),
        .lock_set (lock_set),
        .lock_idx (lock_idx),
        .pb_we    (pb_we),
        .pb_idx   (pb_idx),
        .arr_req  (arr_req),
        .arr_op   (arr_op),
        .arr_blk  (arr_blk),
        .arr_waddr(arr_waddr)
    );

    flash_lock_bits #(.NUM_BLOCKS(NUM_BLOCKS)) u_locks (
        .clk    (clk),
        .rst    (rst),
        .set_en (lock_set),
        .set_idx(lock_idx),
        .locks  (lock_vec)
    );

    flash_page_buf #(.PAGE_WORDS(PAGE_WORDS)) u_page (
        .clk  (clk),
        .we   (pb_we),
        .widx (pb_idx),
        .wdata(bus_wdata),
        .ridx (arr_waddr[PG_W-1:0]),
        .rdata(pb_rdata)
    );

    flash_array_model #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .ERASE_LAT  (ERASE_LAT),
        .PROG_LAT   (PROG_LAT)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .req  (arr_req),
        .op   (arr_op),
        .blk  (arr_blk),
        .waddr(arr_waddr),
        .wdata(pb_rdata),
        .raddr(bus_addr[AW-1:1]),
        .rdata(arr_rdata),
        .busy (arr_busy),
        .done (arr_done)
    );

    assign rd_blk = bus_addr[AW-1 -: BLK_W];

    always_comb begin
        bus_rdata = '0;
        case (rd_mode)
            RM_STATUS: bus_rdata = {8'h00, status_byte(st)};
            RM_LOCK:   bus_rdata[LOCK_RD_BIT] = ~lock_vec[rd_blk];
            default:   bus_rdata = arr_rdata;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [7:0]            cmd,
    input status_t               st,
    input rd_mode_e              mode,
    input phase_e                phase,
    input logic                  arr_req,
    input logic                  arr_busy,
    input logic [NUM_BLOCKS-1:0] lock_vec
);

    // R12: while busy, any write but 0x70 leaves read mode and error flags alone
    a_r12_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (!st.ready && bus_we && (cmd != CMD_RD_STATUS))
        |=> ($stable(mode) && $stable(st.erase_err) && $stable(st.prog_err)));

    // R12: 0x70 during a run selects status reads
    a_r12_status_when_busy: assert property (@(posedge clk) disable iff (rst)
        (!st.ready && bus_we && (cmd == CMD_RD_STATUS)) |=> (mode == RM_STATUS));

    // R4: clear command taken in idle drops both error flags
    a_r4_clear_errors: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (phase == PH_IDLE) && (cmd == CMD_CLR_STATUS))
        |=> (!st.erase_err && !st.prog_err));

    // R6: erase error stays set until a clear command
    a_r6_erase_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (st.erase_err && !(bus_we && (cmd == CMD_CLR_STATUS))) |=> st.erase_err);

    // R7: a lock, once set, holds until reset
    a_r7_lock_persist: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

    // R5: the array never gets a new request while it is still working
    a_r5_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> !arr_busy);

    // R5: ready bit is low whenever the array is working
    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        arr_busy |-> !st.ready);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_we  (bus_we),
    .cmd     (bus_wdata[7:0]),
    .st      (st),
    .mode    (rd_mode),
    .phase   (fsm_phase),
    .arr_req (arr_req),
    .arr_busy(arr_busy),
    .lock_vec(lock_vec)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    flash_cmd_ctrl u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic        we;
        logic [10:0] addr;
        logic [15:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 11'h000, 16'hFFFF},  // R1 array after reset
        '{1'b1, 11'h000, 16'hAB70},  // R2 upper byte ignored, status mode
        '{1'b0, 11'h000, 16'h0080},  // R3 status byte
        '{1'b1, 11'h0FE, 16'h0020},  // block erase
        '{1'b1, 11'h0FE, 16'h00AA},  // wrong confirm
        '{1'b0, 11'h000, 16'h00A0},  // R6 erase error
        '{1'b1, 11'h000, 16'h0077},  // lock program
        '{1'b1, 11'h000, 16'h0011},  // wrong confirm
        '{1'b0, 11'h000, 16'h00B0},  // R6 program error added
        '{1'b1, 11'h000, 16'hFF50},  // clear
        '{1'b0, 11'h000, 16'h0080},  // R4 cleared, mode kept
        '{1'b1, 11'h3FE, 16'h0077},  // lock block 1
        '{1'b1, 11'h3FE, 16'h00D0},
        '{1'b0, 11'h000, 16'h0080},  // R7 status after lock
        '{1'b1, 11'h000, 16'h0071},  // lock status read
        '{1'b0, 11'h3FE, 16'h0000},  // R7 block 1 locked
        '{1'b0, 11'h1FE, 16'h0040},  // R7 block 0 unlocked
        '{1'b1, 11'h000, 16'h12FF},  // read array
        '{1'b0, 11'h3FE, 16'hFFFF}   // R2 array data
    };

    function automatic logic [15:0] pat(int i);
        return {8'(i) ^ 8'hA5, 8'(i)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_ready(input string tag);
        bit ok = 0;
        wr(11'h000, 16'h0070);
        for (int k = 0; k < 5000 && !ok; k++) begin
            @(negedge clk);
            #1;
            ok = bus_rdata[7];
        end
        check(tag, 16'(ok), 16'd1);
    endtask

    task automatic page_prog(input logic [10:0] base, input bit flat);
        wr(base, 16'h0041);
        for (int i = 0; i < 128; i++) begin
            wr(base + 11'(2 * i), flat ? 16'h0F0F : pat(i));
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // table of basic commands (R1..R4, R6, R7)
        for (int v = 0; v < NV; v++) begin
            if (TBL[v].we) wr(TBL[v].addr, TBL[v].data);
            else rd(TBL[v].addr, TBL[v].data, $sformatf("table entry %0d", v));
        end

        // R10 / R12: page program in block 0 with busy-time commands
        page_prog(11'h000, 1'b0);
        rd(11'h000, 16'h0000, "R12 busy status");
        wr(11'h000, 16'h00FF);
        rd(11'h000, 16'h0000, "R12 FF ignored while busy");
        wait_ready("R12 program completes");
        rd(11'h000, 16'h0080, "R3 ready no error");
        wr(11'h000, 16'h00FF);
        rd(11'h000, pat(0),   "R10 word 0");
        rd(11'h00A, pat(5),   "R10 word 5");
        rd(11'h0FE, pat(127), "R10 word 127");
        rd(11'h100, 16'hFFFF, "R10 next page untouched");

        // R10: programming only clears bits
        page_prog(11'h000, 1'b1);
        wait_ready("R10 second program completes");
        wr(11'h000, 16'h00FF);
        rd(11'h00A, pat(5) & 16'h0F0F, "R10 AND of old and new");

        // R8: program into locked block 1
        page_prog(11'h200, 1'b0);
        rd(11'h000, 16'h0090, "R8 program refused");
        wr(11'h000, 16'h00FF);
        rd(11'h200, 16'hFFFF, "R8 locked block unchanged");
        wr(11'h000, 16'h0050);

        // R11: out-of-order page address
        wr(11'h400, 16'h0041);
        wr(11'h400, 16'h1111);
        wr(11'h402, 16'h2222);
        wr(11'h406, 16'h3333);
        rd(11'h000, 16'h0090, "R11 order error");
        wr(11'h000, 16'h00FF);
        rd(11'h400, 16'hFFFF, "R11 nothing written");
        wr(11'h000, 16'h0050);

        // R8: erase of locked block
        wr(11'h3FE, 16'h0020);
        wr(11'h3FE, 16'h00D0);
        rd(11'h000, 16'h00A0, "R8 erase refused");
        wr(11'h000, 16'h0050);

        // R5: block erase of block 0
        wr(11'h1FE, 16'h0020);
        wr(11'h1FE, 16'h00D0);
        rd(11'h000, 16'h0000, "R5 busy during erase");
        wait_ready("R5 erase completes");
        wr(11'h000, 16'h00FF);
        rd(11'h00A, 16'hFFFF, "R5 word erased");
        rd(11'h000, 16'hFFFF, "R5 first word erased");

        // R1: reset clears locks
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(11'h000, 16'hFFFF, "R1 array mode after reset");
        wr(11'h000, 16'h0071);
        rd(11'h3FE, 16'h0040, "R1 block 1 unlocked after reset");
        wr(11'h000, 16'h0070);
        rd(11'h000, 16'h0080, "R1 status after reset");

        // R9: erase all unlocked skips locked block 1
        page_prog(11'h200, 1'b0);
        wait_ready("R9 program block 1");
        page_prog(11'h400, 1'b0);
        wait_ready("R9 program block 2");
        wr(11'h3FE, 16'h0077);
        wr(11'h3FE, 16'h00D0);
        wr(11'h000, 16'h00A7);
        wr(11'h000, 16'h00D0);
        rd(11'h000, 16'h0000, "R9 busy during erase all");
        wait_ready("R9 erase all completes");
        rd(11'h000, 16'h0080, "R9 no error");
        wr(11'h000, 16'h00FF);
        rd(11'h200, pat(0),   "R9 locked block kept word 0");
        rd(11'h20A, pat(5),   "R9 locked block kept word 5");
        rd(11'h40A, 16'hFFFF, "R9 unlocked block erased");

        finish_run();
    end

endmodule